// File: doc/BRIEF.md
# Four-Channel PWM Control Register Front End

This block sits between a simple synchronous register bus and a set of PWM channel counters. It holds the run state of every channel, takes enable and disable requests through two separate strobe registers, and reports which channels are running through a read-only status word. Each channel counter sends a one-cycle pulse when it starts a new period. The block collects these pulses into an interrupt flag word that clears when it is read, and it raises one combined interrupt line while any flag is pending.

A disable request does not stop a channel at once. The channel keeps running until its current period ends, and only then does its run and status bit drop. This ensures that a duty value queued for the current period takes effect before the output stops. Every channel has its own window of five registers at a fixed pitch. Bus accesses that fall in a valid window slot go to that channel as one-hot write and read strobes with a slot index. The channel returns read data on a flat bus that the block selects from.

Top module: `pwm_regfront`

## Requirements
- R1: Out of reset every channel is stopped, the status word and the interrupt flags are zero, `irq` is low and `bus_rdata` is zero.
- R2: A write to offset 0x004 starts every channel whose bit is 1 in the write data. Zero bits leave their channel unchanged. A read of 0x004 or 0x008 returns zero.
- R3: A write of 1 to bit n at offset 0x008 stops a running channel n at its next period-start pulse. `ch_run[n]` and status bit n stay 1 until the clock edge that samples that pulse, then read 0. The same write has no effect on a channel that is already stopped.
- R4: A read of offset 0x00C returns the run state of channel n in bit n, with zeros above. Writes to 0x00C change nothing.
- R5: A period-start pulse on a running channel sets flag n at offset 0x01C. A read of 0x01C returns the flags and clears them. A pulse from a stopped channel sets no flag.
- R6: A period-start pulse in the same cycle as a read of 0x01C is not lost. The read returns the old flags, and the new flag stays set for the next read.
- R7: `irq` is 1 exactly while at least one interrupt flag is set.
- R8: The address 0x200 + n*0x20 + 4*k, with k from 0 to 4, forwards to channel n. It asserts bit n of `ch_wr_en` or `ch_rd_en` in the same cycle, drives `ch_reg_idx` = k, and passes `bus_wdata` on `ch_wdata`. A read returns the selected slice `ch_rdata[n*32 +: 32]`.
- R9: Any other offset is unmapped. This includes unaligned addresses, window slots 0x14 to 0x1C, and addresses at or above 0x280. A read of an unmapped offset returns zero. A write to one changes no state and raises no channel strobe.
- R10: `bus_rdata` carries the data for a read in the cycle after `bus_re`. In a cycle after one without a read, it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| ch_period_start | input | 4 | One-cycle pulse per channel at the start of a period |
| ch_run | output | 4 | Run request and state per channel |
| ch_wr_en | output | 4 | One-hot write strobe into a channel window |
| ch_rd_en | output | 4 | One-hot read strobe into a channel window |
| ch_reg_idx | output | 3 | Slot index within the window |
| ch_wdata | output | 32 | Write data forwarded to the channel |
| ch_rdata | input | 128 | Read data of all channels, channel n at bits n*32 +: 32 |
| irq | output | 1 | OR of the pending interrupt flags |

## Verification
Writes to the strobe registers and period-start pulses change `ch_run`, the status word and the flags at the first clock edge after the stimulus. Channel strobes and their index are combinational in the stimulus cycle. Read data appears one edge after `bus_re`. The bench drives every stimulus on the falling edge and samples 1 ns after the rising edge that must produce the result. In that way each read reflects exactly the writes and pulses of the earlier cycles. In the coincident-pulse case, the pulse and the read of the flag word are driven in the same cycle, and two reads in a row separate the old flags from the new flag.

// File: rtl/pwm_regfront_pkg.sv
package pwm_regfront_pkg;
  localparam int unsigned OFS_START  = 32'h004;
  localparam int unsigned OFS_STOP   = 32'h008;
  localparam int unsigned OFS_STATUS = 32'h00C;
  localparam int unsigned OFS_FLAGS  = 32'h01C;

  // slot index inside a window from the offset relative to the window base
  function automatic int unsigned slot_of(int unsigned rel_ofs);
    return rel_ofs >> 2;
  endfunction

  // an in-window offset is valid when word aligned and below the slot count
  function automatic logic slot_ok(int unsigned rel_ofs, int unsigned n_slots);
    return ((rel_ofs & 3) == 0) && (slot_of(rel_ofs) < n_slots);
  endfunction
endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
  import pwm_regfront_pkg::*;
#(
  parameter int AW       = 12,
  parameter int N_CH     = 4,
  parameter int WIN_BASE = 32'h200,
  parameter int PITCH_LG = 5,
  parameter int WIN_REGS = 5,
  parameter int CW       = (N_CH > 1) ? $clog2(N_CH) : 1,
  parameter int IW       = 3
) (
  input  logic [AW-1:0] addr,
  output logic          hit_start,
  output logic          hit_stop,
  output logic          hit_status,
  output logic          hit_flags,
  output logic          hit_win,
  output logic [CW-1:0] win_ch,
  output logic [IW-1:0] win_idx
);
  localparam logic [AW-1:0] BASE_V = AW'(WIN_BASE);
  localparam logic [AW-1:0] END_V  = AW'(WIN_BASE + (N_CH << PITCH_LG));

  logic [AW-1:0]       rel;
  logic [PITCH_LG-1:0] ofs;
  logic                in_range;

  always_comb begin
    hit_start  = (addr == AW'(OFS_START));
    hit_stop   = (addr == AW'(OFS_STOP));
    hit_status = (addr == AW'(OFS_STATUS));
    hit_flags  = (addr == AW'(OFS_FLAGS));
    rel        = addr - BASE_V;
    ofs        = rel[PITCH_LG-1:0];
    in_range   = (addr >= BASE_V) && (addr < END_V);
    hit_win    = in_range && slot_ok(int'(ofs), WIN_REGS);
    win_ch     = rel[PITCH_LG +: CW];
    win_idx    = IW'(slot_of(int'(ofs)));
  end
endmodule

// File: rtl/pwm_run_ctrl.sv
module pwm_run_ctrl #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] start_mask,
  input  logic [N_CH-1:0] stop_mask,
  input  logic [N_CH-1:0] period_start,
  output logic [N_CH-1:0] run,
  output logic [N_CH-1:0] stopping
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run[i]      <= 1'b0;
        stopping[i] <= 1'b0;
      end else if (start_mask[i]) begin
        run[i]      <= 1'b1;
        stopping[i] <= 1'b0;
      end else if (stopping[i] && period_start[i]) begin
        run[i]      <= 1'b0;
        stopping[i] <= 1'b0;
      end else if (stop_mask[i] && run[i]) begin
        stopping[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_irq_flags.sv
module pwm_irq_flags #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] rise,
  input  logic            clr_rd,
  output logic [N_CH-1:0] flags,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flags <= '0;
    else if (clr_rd) flags <= rise;          // keep a flag raised during the read
    else             flags <= flags | rise;
  end

  assign irq = |flags;
endmodule

// File: rtl/pwm_regfront.sv
module pwm_regfront #(
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int N_CH     = 4,
  parameter int WIN_BASE = 32'h200,
  parameter int PITCH_LG = 5,
  parameter int WIN_REGS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_re,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_CH-1:0]  ch_period_start,
  output logic [N_CH-1:0]  ch_run,
  output logic [N_CH-1:0]  ch_wr_en,
  output logic [N_CH-1:0]  ch_rd_en,
  output logic [2:0]       ch_reg_idx,
  output logic [DW-1:0]    ch_wdata,
  input  logic [N_CH*DW-1:0] ch_rdata,
  output logic             irq
);
  localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic          hit_start, hit_stop, hit_status, hit_flags, hit_win;
  logic [CW-1:0] win_ch;
  logic [2:0]    win_idx;
  logic [N_CH-1:0] start_mask, stop_mask, stopping, flag_rise, flags, win_sel;
  logic          flags_rd;
  logic [DW-1:0] rd_next;

  pwm_addr_decode #(
    .AW(AW), .N_CH(N_CH), .WIN_BASE(WIN_BASE), .PITCH_LG(PITCH_LG),
    .WIN_REGS(WIN_REGS), .CW(CW), .IW(3)
  ) u_dec (
    .addr(bus_addr), .hit_start(hit_start), .hit_stop(hit_stop),
    .hit_status(hit_status), .hit_flags(hit_flags), .hit_win(hit_win),
    .win_ch(win_ch), .win_idx(win_idx)
  );

  assign start_mask = (bus_we && hit_start) ? bus_wdata[N_CH-1:0] : '0;
  assign stop_mask  = (bus_we && hit_stop)  ? bus_wdata[N_CH-1:0] : '0;

  pwm_run_ctrl #(.N_CH(N_CH)) u_run (
    .clk(clk), .rst_n(rst_n), .start_mask(start_mask), .stop_mask(stop_mask),
    .period_start(ch_period_start), .run(ch_run), .stopping(stopping)
  );

  assign flag_rise = ch_period_start & ch_run;
  assign flags_rd  = bus_re && hit_flags;

  pwm_irq_flags #(.N_CH(N_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .rise(flag_rise), .clr_rd(flags_rd),
    .flags(flags), .irq(irq)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_win
    assign win_sel[i]  = hit_win && (win_ch == CW'(i));
    assign ch_wr_en[i] = bus_we && win_sel[i];
    assign ch_rd_en[i] = bus_re && win_sel[i];
  end
  assign ch_reg_idx = win_idx;
  assign ch_wdata   = bus_wdata;

  always_comb begin
    rd_next = '0;
    if (hit_status)     rd_next = DW'(ch_run);
    else if (hit_flags) rd_next = DW'(flags);
    else if (hit_win)   rd_next = ch_rdata[win_ch*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/pwm_regfront_chk.sv
module pwm_regfront_chk #(
  parameter int DW   = 32,
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_re,
  input logic            bus_we,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [N_CH-1:0] ch_period_start,
  input logic [N_CH-1:0] ch_run,
  input logic [N_CH-1:0] ch_wr_en,
  input logic [N_CH-1:0] ch_rd_en,
  input logic            irq,
  input logic [N_CH-1:0] flags,
  input logic            hit_start,
  input logic            hit_stop,
  input logic            hit_status,
  input logic            hit_flags,
  input logic            hit_win,
  input logic            flags_rd
);
  logic hit_any;
  assign hit_any = hit_start | hit_stop | hit_status | hit_flags | hit_win;

  // R2: started channels run after the edge
  p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_start) |=>
      ((ch_run & $past(bus_wdata[N_CH-1:0])) == $past(bus_wdata[N_CH-1:0])));

  // R3: a run bit only falls after a period-start pulse
  p_stop_at_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ch_run) & ~ch_run) & ~$past(ch_period_start)) == '0));

  // R5 and R6: a read leaves exactly the pulses of the read cycle
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_rd |=> (flags == $past(ch_period_start & ch_run)));

  // R7: no pending flag and no pulse keeps irq low
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (ch_period_start == '0)) |=> !irq);

  // R8: at most one channel strobed
  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr_en | ch_rd_en));

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !hit_any) |=> (bus_rdata == '0));

  // R10: no read, zero data
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));
endmodule

bind pwm_regfront pwm_regfront_chk #(.DW(DW), .N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ch_period_start(ch_period_start), .ch_run(ch_run),
  .ch_wr_en(ch_wr_en), .ch_rd_en(ch_rd_en), .irq(irq), .flags(flags),
  .hit_start(hit_start), .hit_stop(hit_stop), .hit_status(hit_status),
  .hit_flags(hit_flags), .hit_win(hit_win), .flags_rd(flags_rd)
);

// File: tb/tb_pwm_regfront.sv
`timescale 1ns/1ps
module tb_pwm_regfront;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_re = 1'b0;
  logic [31:0]  bus_rdata;
  logic [3:0]   ch_period_start = '0;
  logic [3:0]   ch_run, ch_wr_en, ch_rd_en;
  logic [2:0]   ch_reg_idx;
  logic [31:0]  ch_wdata;
  logic [127:0] ch_rdata;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  int strobes = 0;

  always #5 clk = ~clk;

  pwm_regfront dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .ch_period_start(ch_period_start), .ch_run(ch_run),
    .ch_wr_en(ch_wr_en), .ch_rd_en(ch_rd_en), .ch_reg_idx(ch_reg_idx),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .irq(irq)
  );

  // simple channel register model
  logic [31:0] mdl [4][8];
  initial for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) mdl[c][k] = '0;
  always @(posedge clk) begin
    for (int c = 0; c < 4; c++) if (ch_wr_en[c]) mdl[c][ch_reg_idx] <= ch_wdata;
    if ((ch_wr_en | ch_rd_en) != '0) strobes <= strobes + 1;
  end
  always_comb for (int c = 0; c < 4; c++) ch_rdata[c*32 +: 32] = mdl[c][ch_reg_idx];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] pm, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; ch_period_start = pm;
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0; ch_period_start = '0;
  endtask

  task automatic pulse(input logic [3:0] pm);
    @(negedge clk); ch_period_start = pm;
    @(posedge clk); #1;
    @(negedge clk); ch_period_start = '0;
  endtask

  function automatic string req_of(input logic [11:0] a);
    if (a == 12'h00C) return "R4";
    if (a == 12'h004 || a == 12'h008) return "R2";
    if (a == 12'h01C) return "R5";
    if (a >= 12'h200 && a < 12'h280 && a[1:0] == 2'b00 && a[4:2] < 3'd5) return "R8";
    return "R9";
  endfunction

  // {write, addr, data/expected}
  localparam int NV = 20;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 12'h00C, 32'h0},    {1'b1, 12'h004, 32'h5},
    {1'b0, 12'h00C, 32'h5},    {1'b1, 12'h004, 32'h0},
    {1'b0, 12'h00C, 32'h5},    {1'b1, 12'h004, 32'hA},
    {1'b0, 12'h00C, 32'hF},    {1'b1, 12'h00C, 32'h0},
    {1'b0, 12'h00C, 32'hF},    {1'b0, 12'h01C, 32'h0},
    {1'b1, 12'h204, 32'h1234}, {1'b0, 12'h204, 32'h1234},
    {1'b1, 12'h270, 32'hBEEF}, {1'b0, 12'h270, 32'hBEEF},
    {1'b0, 12'h004, 32'h0},    {1'b0, 12'h010, 32'h0},
    {1'b0, 12'h280, 32'h0},    {1'b0, 12'h206, 32'h0},
    {1'b1, 12'h214, 32'hDEAD}, {1'b0, 12'h214, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 run", {28'h0, ch_run}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][44]) wr(VEC[v][43:32], VEC[v][31:0]);
      else begin
        rd(VEC[v][43:32], 4'h0, d);
        check(req_of(VEC[v][43:32]), d, VEC[v][31:0]);
      end
    end

    // R8: same-cycle strobe and index
    @(negedge clk); bus_addr = 12'h26C; bus_wdata = 32'h77; bus_we = 1'b1;
    #1 check("R8 wr_en", {28'h0, ch_wr_en}, 32'h8);
    check("R8 idx", {29'h0, ch_reg_idx}, 32'h3);
    @(negedge clk); bus_we = 1'b0;

    // R9: unmapped writes raise no strobe and change no state
    s0 = strobes;
    wr(12'h214, 32'hFFFF); wr(12'h010, 32'hFFFF); wr(12'h282, 32'hFFFF);
    check("R9 strobes", strobes - s0, 32'h0);
    rd(12'h00C, 4'h0, d); check("R9 status", d, 32'hF);
    rd(12'h01C, 4'h0, d); check("R9 flags", d, 32'h0);

    // R10: data only after a read
    @(posedge clk); #1 check("R10 idle", bus_rdata, 32'h0);

    // R3: delayed stop
    wr(12'h008, 32'h1);
    check("R3 still run", {28'h0, ch_run}, 32'hF);
    rd(12'h00C, 4'h0, d); check("R3 status before", d, 32'hF);
    pulse(4'h1);
    check("R3 stopped", {28'h0, ch_run}, 32'hE);
    rd(12'h00C, 4'h0, d); check("R3 status after", d, 32'hE);
    rd(12'h01C, 4'h0, d); check("R5 last period flag", d, 32'h1);
    wr(12'h008, 32'h1);
    rd(12'h00C, 4'h0, d); check("R3 stopped no effect", d, 32'hE);

    // R5 and R7
    pulse(4'h2);
    check("R7 irq high", {31'h0, irq}, 32'h1);
    rd(12'h01C, 4'h0, d); check("R5 flag", d, 32'h2);
    check("R7 irq low", {31'h0, irq}, 32'h0);
    rd(12'h01C, 4'h0, d); check("R5 cleared", d, 32'h0);
    pulse(4'h1);
    rd(12'h01C, 4'h0, d); check("R5 stopped gated", d, 32'h0);

    // R6: pulse in the read cycle
    pulse(4'h4);
    rd(12'h01C, 4'h8, d); check("R6 old flags", d, 32'h4);
    check("R6 irq kept", {31'h0, irq}, 32'h1);
    rd(12'h01C, 4'h0, d); check("R6 new flag", d, 32'h8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule